// File: doc/BRIEF.md
# Set/Way Cache Clean Decoder

This block sits after the coprocessor-register decode stage. It takes a decoded register-write access (coprocessor number, opc1, CRn, CRm, opc2), the 32-bit operand and the current privilege context. It recognises the clean-data-line-by-set/way operation. For a recognised access it resolves the privilege checks and the hypervisor trap checks in a fixed order. It then splits the operand into cache level, set and way, using the geometry of the selected level, which is given as parameters.

Every recognised access produces exactly one outcome:

- an undefined-instruction pulse;
- a hypervisor trap pulse, carrying the trap style and the syndrome code;
- an out-of-range pulse;
- a clean request to the cache, held on a valid/ready channel.

Accesses that are not recognised are consumed and produce no outcome at all.

Back-pressure works as follows. The access input is accepted on a cycle where `op_valid` and `op_ready` are both high. `op_ready` is low while a clean request is waiting on the cache. The cache side follows the usual rules: once `cln_valid` rises, the request and its level, set and way stay unchanged until a cycle in which `cln_ready` is high. The request leaves the channel on that edge.

Top module: `swc_clean_decoder`

## Requirements
- R1: An access is recognised only when coprocessor = 4'b1111, opc1 = 3'b000, CRn = 4'b0111, CRm = 4'b1010 and opc2 = 3'b010.
- R2: The privilege input uses the encoding 0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor. A recognised access at user level gives `res_undef`, whatever the operand and the trap bits.
- R3: At kernel level with `hyp_on` = 1, the checks run in this order, and the first one that applies decides the outcome:
  1. CRn-7 trap bit of the 64-bit hypervisor.
  2. CRn-7 trap bit of the 32-bit hypervisor.
  3. Set/way trap bit of the 64-bit hypervisor.
  4. Set/way trap bit of the 32-bit hypervisor.

  `res_trap_cause` is 0 for a CRn-7 trap and 1 for a set/way trap.
- R4: A trap bit belonging to the hypervisor width that is not in use (selected by `hyp_64`) has no effect. With `hyp_on` = 0, no trap bit has an effect.
- R5: A trap sets `res_syndrome` to 6'h03 and sets `res_trap_h64` equal to `hyp_64`. When there is no trap, both are 0.
- R6: At hypervisor and monitor levels, the clean is issued whatever the trap bits are.
- R7: The operand fields are split as follows:
  - Level is operand bits [3:1] (0 = first level).
  - For a level with A = ceil(log2(ways)), S = ceil(log2(sets)) and L = log2(line bytes), the way is bits [31:32-A] and the set is bits [L+S-1:L].
  - Bit 0, bits [L-1:4] and the bits between the set and the way fields are ignored.
- R8: A level ≥ the number of levels, a way ≥ the level's associativity, or a set ≥ the level's set count gives `res_range_err` and no clean request. The undefined and trap outcomes take precedence over this check.
- R9: Exactly one outcome appears in the cycle after acceptance. `res_undef`, `res_trap` and `res_range_err` are each high for that one cycle only.
- R10: A clean request holds `cln_valid`, `cln_level`, `cln_set` and `cln_way` stable until `cln_ready` is high. `op_ready` is low while the request is pending, and an offered access is not taken.
- R11: An access that is not recognised is consumed and asserts no outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Access offered |
| op_ready | output | 1 | Access can be taken (no request pending) |
| op_coproc | input | 4 | Coprocessor number |
| op_opc1 | input | 3 | opc1 field |
| op_crn | input | 4 | CRn field |
| op_crm | input | 4 | CRm field |
| op_opc2 | input | 3 | opc2 field |
| op_data | input | 32 | Set/way/level operand |
| priv_level | input | 2 | Privilege level of the access |
| hyp_on | input | 1 | Hypervisor enabled |
| hyp_64 | input | 1 | Hypervisor runs 64-bit |
| cr7_trap_h64 | input | 1 | CRn-7 trap bit, 64-bit hypervisor |
| cr7_trap_h32 | input | 1 | CRn-7 trap bit, 32-bit hypervisor |
| sw_trap_h64 | input | 1 | Set/way trap bit, 64-bit hypervisor |
| sw_trap_h32 | input | 1 | Set/way trap bit, 32-bit hypervisor |
| res_undef | output | 1 | Undefined-instruction pulse |
| res_trap | output | 1 | Hypervisor trap pulse |
| res_trap_h64 | output | 1 | Trap style: 1 = 64-bit system-access trap |
| res_trap_cause | output | 1 | 0 = CRn-7 trap, 1 = set/way trap |
| res_syndrome | output | 6 | Trap syndrome code |
| res_range_err | output | 1 | Out-of-range argument pulse |
| cln_valid | output | 1 | Clean request valid |
| cln_ready | input | 1 | Cache accepts the request |
| cln_level | output | 3 | Target level minus one |
| cln_set | output | SET_W | Set index |
| cln_way | output | WAY_W | Way index |

## Verification
The bench uses a default geometry in which one level has a set count that is not a power of two and the other has an associativity that is not a power of two. This makes the set and way range checks reachable. A decoder that compares field widths instead of counts would issue those cleans.

The bench drives trap bits of both hypervisor widths at the same time. A priority chain in the wrong order, or one that ignores the hypervisor width, shows up as the wrong cause or style, or as a trap where the clean should go through.

Operands carry set bits in the reserved and gap regions, so a wrong field split corrupts the set or the level. A second access is offered while the cache withholds ready; a design that takes it, or that lets the held fields drift, is caught.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_MON    = 2'd3
  } priv_e;

  localparam logic [3:0] SWC_COPROC = 4'b1111;
  localparam logic [2:0] SWC_OPC1   = 3'b000;
  localparam logic [3:0] SWC_CRN    = 4'b0111;
  localparam logic [3:0] SWC_CRM    = 4'b1010;
  localparam logic [2:0] SWC_OPC2   = 3'b010;

  localparam int unsigned SYN_W = 6;
  localparam logic [SYN_W-1:0] SWC_SYNDROME = 6'h03;

  localparam logic CAUSE_CR7 = 1'b0;
  localparam logic CAUSE_SW  = 1'b1;

  typedef struct packed {
    logic undef;
    logic trap;
    logic trap_h64;
    logic cause;
    logic issue;
  } gate_res_t;

endpackage

// File: rtl/swc_op_match.sv
module swc_op_match
  import swc_pkg::*;
(
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);

  logic [4:0] field_ok;

  always_comb begin
    field_ok[0] = (coproc == SWC_COPROC);
    field_ok[1] = (opc1   == SWC_OPC1);
    field_ok[2] = (crn    == SWC_CRN);
    field_ok[3] = (crm    == SWC_CRM);
    field_ok[4] = (opc2   == SWC_OPC2);
    hit         = &field_ok;
  end

endmodule

// File: rtl/swc_trap_gate.sv
module swc_trap_gate
  import swc_pkg::*;
(
  input  logic [1:0] priv_level,
  input  logic       hyp_on,
  input  logic       hyp_64,
  input  logic       cr7_trap_h64,
  input  logic       cr7_trap_h32,
  input  logic       sw_trap_h64,
  input  logic       sw_trap_h32,
  output gate_res_t  res
);

  priv_e lvl;
  logic  t_cr7, t_sw;

  always_comb begin
    lvl   = priv_e'(priv_level);
    // Only the bits of the hypervisor width in use participate.
    t_cr7 = hyp_64 ? cr7_trap_h64 : cr7_trap_h32;
    t_sw  = hyp_64 ? sw_trap_h64  : sw_trap_h32;
    res   = '0;
    unique case (lvl)
      PRIV_USER: res.undef = 1'b1;
      PRIV_KERNEL: begin
        if (hyp_on && t_cr7) begin
          res.trap     = 1'b1;
          res.trap_h64 = hyp_64;
          res.cause    = CAUSE_CR7;
        end else if (hyp_on && t_sw) begin
          res.trap     = 1'b1;
          res.trap_h64 = hyp_64;
          res.cause    = CAUSE_SW;
        end else begin
          res.issue = 1'b1;
        end
      end
      default: res.issue = 1'b1;
    endcase
  end

endmodule

// File: rtl/swc_geom_split.sv
module swc_geom_split #(
  parameter int unsigned NUM_LEVELS = 2,
  parameter int unsigned WAY_W      = 3,
  parameter int unsigned SET_W      = 9,
  parameter int unsigned LVL_WAYS  [NUM_LEVELS] = '{4, 6},
  parameter int unsigned LVL_SETS  [NUM_LEVELS] = '{96, 512},
  parameter int unsigned LVL_LINE  [NUM_LEVELS] = '{64, 128}
) (
  input  logic [31:0]      op_data,
  output logic [2:0]       level,
  output logic [SET_W-1:0] set_idx,
  output logic [WAY_W-1:0] way_idx,
  output logic             bad
);

  logic [WAY_W-1:0] way_arr [NUM_LEVELS];
  logic [SET_W-1:0] set_arr [NUM_LEVELS];
  logic             bad_arr [NUM_LEVELS];
  logic             unused_data;

  assign unused_data = ^op_data;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    localparam int unsigned A = $clog2(LVL_WAYS[g]);
    localparam int unsigned S = $clog2(LVL_SETS[g]);
    localparam int unsigned L = $clog2(LVL_LINE[g]);

    if (A == 0) begin : g_noway
      assign way_arr[g] = '0;
    end else begin : g_way
      assign way_arr[g] = WAY_W'(op_data[31 -: A]);
    end

    if (S == 0) begin : g_noset
      assign set_arr[g] = '0;
    end else begin : g_set
      assign set_arr[g] = SET_W'(op_data[L +: S]);
    end

    assign bad_arr[g] = (32'(way_arr[g]) >= LVL_WAYS[g]) ||
                        (32'(set_arr[g]) >= LVL_SETS[g]);
  end

  always_comb begin
    level   = op_data[3:1];
    set_idx = '0;
    way_idx = '0;
    bad     = 1'b1;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level == 3'(i)) begin
        set_idx = set_arr[i];
        way_idx = way_arr[i];
        bad     = bad_arr[i];
      end
    end
  end

endmodule

// File: rtl/swc_clean_decoder.sv
module swc_clean_decoder
  import swc_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 2,
  parameter int unsigned LVL_WAYS  [NUM_LEVELS] = '{4, 6},
  parameter int unsigned LVL_SETS  [NUM_LEVELS] = '{96, 512},
  parameter int unsigned LVL_LINE  [NUM_LEVELS] = '{64, 128},
  localparam int unsigned WAY_W = calc_way_w(),
  localparam int unsigned SET_W = calc_set_w()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [3:0]       op_coproc,
  input  logic [2:0]       op_opc1,
  input  logic [3:0]       op_crn,
  input  logic [3:0]       op_crm,
  input  logic [2:0]       op_opc2,
  input  logic [31:0]      op_data,
  input  logic [1:0]       priv_level,
  input  logic             hyp_on,
  input  logic             hyp_64,
  input  logic             cr7_trap_h64,
  input  logic             cr7_trap_h32,
  input  logic             sw_trap_h64,
  input  logic             sw_trap_h32,
  output logic             res_undef,
  output logic             res_trap,
  output logic             res_trap_h64,
  output logic             res_trap_cause,
  output logic [5:0]       res_syndrome,
  output logic             res_range_err,
  output logic             cln_valid,
  input  logic             cln_ready,
  output logic [2:0]       cln_level,
  output logic [SET_W-1:0] cln_set,
  output logic [WAY_W-1:0] cln_way
);

  function automatic int unsigned calc_way_w();
    int unsigned m = 1;
    for (int i = 0; i < NUM_LEVELS; i++)
      if ($clog2(LVL_WAYS[i]) > m) m = $clog2(LVL_WAYS[i]);
    return m;
  endfunction

  function automatic int unsigned calc_set_w();
    int unsigned m = 1;
    for (int i = 0; i < NUM_LEVELS; i++)
      if ($clog2(LVL_SETS[i]) > m) m = $clog2(LVL_SETS[i]);
    return m;
  endfunction

  logic             op_hit;
  gate_res_t        gate;
  logic [2:0]       sp_level;
  logic [SET_W-1:0] sp_set;
  logic [WAY_W-1:0] sp_way;
  logic             sp_bad;
  logic             fire;

  swc_op_match u_match (
    .coproc (op_coproc),
    .opc1   (op_opc1),
    .crn    (op_crn),
    .crm    (op_crm),
    .opc2   (op_opc2),
    .hit    (op_hit)
  );

  swc_trap_gate u_gate (
    .priv_level   (priv_level),
    .hyp_on       (hyp_on),
    .hyp_64       (hyp_64),
    .cr7_trap_h64 (cr7_trap_h64),
    .cr7_trap_h32 (cr7_trap_h32),
    .sw_trap_h64  (sw_trap_h64),
    .sw_trap_h32  (sw_trap_h32),
    .res          (gate)
  );

  swc_geom_split #(
    .NUM_LEVELS (NUM_LEVELS),
    .WAY_W      (WAY_W),
    .SET_W      (SET_W),
    .LVL_WAYS   (LVL_WAYS),
    .LVL_SETS   (LVL_SETS),
    .LVL_LINE   (LVL_LINE)
  ) u_split (
    .op_data (op_data),
    .level   (sp_level),
    .set_idx (sp_set),
    .way_idx (sp_way),
    .bad     (sp_bad)
  );

  assign op_ready = !cln_valid;
  assign fire     = op_valid && op_ready && op_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_undef      <= 1'b0;
      res_trap       <= 1'b0;
      res_trap_h64   <= 1'b0;
      res_trap_cause <= 1'b0;
      res_syndrome   <= '0;
      res_range_err  <= 1'b0;
      cln_valid      <= 1'b0;
      cln_level      <= '0;
      cln_set        <= '0;
      cln_way        <= '0;
    end else begin
      res_undef      <= fire && gate.undef;
      res_trap       <= fire && gate.trap;
      res_trap_h64   <= fire && gate.trap && gate.trap_h64;
      res_trap_cause <= fire && gate.trap && gate.cause;
      res_syndrome   <= (fire && gate.trap) ? SWC_SYNDROME : '0;
      res_range_err  <= fire && gate.issue && sp_bad;
      if (fire && gate.issue && !sp_bad) begin
        cln_valid <= 1'b1;
        cln_level <= sp_level;
        cln_set   <= sp_set;
        cln_way   <= sp_way;
      end else if (cln_valid && cln_ready) begin
        cln_valid <= 1'b0;
      end
    end
  end

  p_user_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_hit && priv_level == 2'd0) |=> res_undef);

  p_trap_syn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap |-> (res_syndrome == 6'h03 && res_trap_h64 == $past(hyp_64)));

  p_high_priv_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_hit && priv_level[1]) |=> (!res_undef && !res_trap));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_undef, res_trap, res_range_err, cln_valid}));

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cln_valid && !cln_ready) |=> (cln_valid && $stable(cln_level) &&
                                   $stable(cln_set) && $stable(cln_way)));

  p_unclaimed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_hit) |=>
      (!res_undef && !res_trap && !res_range_err && !cln_valid));

endmodule

// File: tb/swc_clean_decoder_tb_top.sv
`timescale 1ns/1ps
module swc_clean_decoder_tb_top;

  localparam logic [3:0] E_UNDEF = 4'b0001;
  localparam logic [3:0] E_TRAP  = 4'b0010;
  localparam logic [3:0] E_REQ   = 4'b0100;
  localparam logic [3:0] E_RANGE = 4'b1000;

  typedef struct packed {
    logic [1:0]  priv;
    logic        hen, h64, c7w, c7n, sww, swn;
    logic [31:0] data;
    logic [3:0]  exp;
    logic        cause;
    logic        style;
    logic [2:0]  lvl;
    logic [8:0]  set;
    logic [2:0]  way;
  } vec_t;

  localparam logic [31:0] D_L1 = (32'd2 << 30) | (32'd5 << 6);

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, D_L1, E_UNDEF, 1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, D_L1, E_TRAP,  1'b0,1'b1, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, D_L1, E_TRAP,  1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, D_L1, E_TRAP,  1'b1,1'b1, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, D_L1, E_TRAP,  1'b1,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, D_L1, E_REQ,   1'b0,1'b0, 3'd0, 9'd5, 3'd2},
    '{2'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,
      (32'd5 << 29) | (32'd300 << 7) | (32'd1 << 1), E_REQ, 1'b0,1'b0, 3'd1, 9'd300, 3'd5},
    '{2'd2, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,
      (32'd3 << 30) | (32'd95 << 6) | (32'd1 << 20) | 32'h31, E_REQ, 1'b0,1'b0, 3'd0, 9'd95, 3'd3},
    '{2'd3, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,
      (32'd511 << 7) | 32'h73, E_REQ, 1'b0,1'b0, 3'd1, 9'd511, 3'd0},
    '{2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'd96 << 6, E_RANGE, 1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,
      (32'd6 << 29) | (32'd1 << 1), E_RANGE, 1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'd2 << 1, E_RANGE, 1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 32'd2 << 1, E_UNDEF, 1'b0,1'b0, 3'd0, 9'd0, 3'd0},
    '{2'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'd96 << 6, E_TRAP, 1'b1,1'b1, 3'd0, 9'd0, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_coproc = 4'b1111;
  logic [2:0]  op_opc1 = 3'b000;
  logic [3:0]  op_crn = 4'b0111;
  logic [3:0]  op_crm = 4'b1010;
  logic [2:0]  op_opc2 = 3'b010;
  logic [31:0] op_data = '0;
  logic [1:0]  priv_level = 2'd0;
  logic        hyp_on = 1'b0, hyp_64 = 1'b0;
  logic        cr7_trap_h64 = 1'b0, cr7_trap_h32 = 1'b0;
  logic        sw_trap_h64 = 1'b0, sw_trap_h32 = 1'b0;
  logic        res_undef, res_trap, res_trap_h64, res_trap_cause, res_range_err;
  logic [5:0]  res_syndrome;
  logic        cln_valid;
  logic        cln_ready = 1'b1;
  logic [2:0]  cln_level;
  logic [8:0]  cln_set;
  logic [2:0]  cln_way;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  swc_clean_decoder dut_i (
    .clk, .rst_n, .op_valid, .op_ready, .op_coproc, .op_opc1, .op_crn, .op_crm,
    .op_opc2, .op_data, .priv_level, .hyp_on, .hyp_64, .cr7_trap_h64, .cr7_trap_h32,
    .sw_trap_h64, .sw_trap_h32, .res_undef, .res_trap, .res_trap_h64, .res_trap_cause,
    .res_syndrome, .res_range_err, .cln_valid, .cln_ready, .cln_level, .cln_set, .cln_way
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outcome();
    return {res_range_err, cln_valid, res_trap, res_undef};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    check("R9 reset outcome", 64'(outcome()), 64'h0);
    check("R5 reset syndrome", 64'(res_syndrome), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", 64'(op_ready), 64'h1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      priv_level   = VEC[i].priv;
      hyp_on       = VEC[i].hen;
      hyp_64       = VEC[i].h64;
      cr7_trap_h64 = VEC[i].c7w;
      cr7_trap_h32 = VEC[i].c7n;
      sw_trap_h64  = VEC[i].sww;
      sw_trap_h32  = VEC[i].swn;
      op_data      = VEC[i].data;
      op_valid     = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check($sformatf("R3 R4 R8 vec%0d outcome", i), 64'(outcome()), 64'(VEC[i].exp));
      if (VEC[i].exp == E_TRAP) begin
        check($sformatf("R3 vec%0d cause", i), 64'(res_trap_cause), 64'(VEC[i].cause));
        check($sformatf("R5 vec%0d style", i), 64'(res_trap_h64), 64'(VEC[i].style));
        check($sformatf("R5 vec%0d syndrome", i), 64'(res_syndrome), 64'h03);
      end else begin
        check($sformatf("R5 vec%0d no syndrome", i), 64'(res_syndrome), 64'h0);
      end
      if (VEC[i].exp == E_REQ)
        check($sformatf("R7 R6 vec%0d fields", i),
              64'({cln_level, cln_set, cln_way}),
              64'({VEC[i].lvl, VEC[i].set, VEC[i].way}));
      @(negedge clk);
      check($sformatf("R9 vec%0d single-cycle", i), 64'(outcome()), 64'h0);
    end

    // R1 R11: one field wrong at a time, otherwise a clean at monitor level
    priv_level = 2'd3;
    op_data    = D_L1;
    for (int f = 0; f < 5; f++) begin
      op_coproc = (f == 0) ? 4'b1110 : 4'b1111;
      op_opc1   = (f == 1) ? 3'b001  : 3'b000;
      op_crn    = (f == 2) ? 4'b0110 : 4'b0111;
      op_crm    = (f == 3) ? 4'b1011 : 4'b1010;
      op_opc2   = (f == 4) ? 3'b011  : 3'b010;
      op_valid  = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check($sformatf("R1 R11 field%0d unclaimed", f), 64'(outcome()), 64'h0);
      check($sformatf("R11 field%0d ready", f), 64'(op_ready), 64'h1);
    end
    op_coproc = 4'b1111; op_opc1 = 3'b000; op_crn = 4'b0111;
    op_crm = 4'b1010; op_opc2 = 3'b010;

    // R10: back-pressure hold, second access refused
    cln_ready  = 1'b0;
    priv_level = 2'd3;
    op_data    = (32'd3 << 29) | (32'd7 << 7) | (32'd1 << 1);
    op_valid   = 1'b1;
    @(negedge clk);
    check("R10 request raised", 64'(outcome()), 64'(E_REQ));
    priv_level = 2'd0;
    op_data    = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check($sformatf("R10 hold%0d", k), 64'({cln_valid, cln_level, cln_set, cln_way}),
            64'({1'b1, 3'd1, 9'd7, 3'd3}));
      check($sformatf("R10 refuse%0d", k), 64'({op_ready, res_undef}), 64'h0);
    end
    op_valid  = 1'b0;
    cln_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", 64'({cln_valid, op_ready}), 64'b01);
    @(negedge clk);
    check("R10 refused access never surfaced", 64'(outcome()), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule